// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is the execution half of a small processor. It pairs an eight-entry register file with one shared function unit. Every clock cycle it takes one packed 16-bit control word, which names two source registers and one destination register. The word also chooses whether the second operand is a register or an external constant, which arithmetic, logic or shift operation runs, and whether the value written back is the function result or an external data word. Whatever produces the control word, fetch and sequencing included, sits outside the block.

Both operand buses leave the block: the first operand as an address output and the second as a data output. Four status flags (overflow, carry, negative, zero) describe the current function-unit result combinationally. The register width is a parameter, 8 bits by default.

Top module: `cw_datapath`

## Requirements
- R1: The control word is packed MSB to LSB as destination select [15:13], A select [12:10], B select [9:7], B-constant flag [6], function code [5:2], writeback-source flag [1] and write enable [0]. With write enable 1 and writeback-source 1, the destination register takes `ext_in` at the rising edge. For example, word 1000000110011011 loads register 4.
- R2: With write enable 0, no register changes. For example, word 0100000110011000 leaves every register as it was.
- R3: `addr_out` always shows the register chosen by the A select.
- R4: With the B-constant flag 0, `data_out` shows the register chosen by the B select. With the flag 1, it shows `const_in`.
- R5: With writeback-source 0 and write enable 1, the destination register takes the function-unit result.
- R6: Function codes 0xxx are arithmetic and compute A + Y + c. Here c is code bit 0, and Y is chosen by code bits 2:1: 00 gives zero, 01 gives B, 10 gives ~B, 11 gives all ones. C is the carry out of that sum. So 0010 is A+B, 0101 is A-B, 0001 is A+1 and 0110 is A-1.
- R7: For arithmetic codes, V is 1 exactly when A and Y have the same sign and the result has the other sign.
- R8: Codes 1xxx are 1000 A AND B, 1001 A OR B, 1010 A XOR B, 1011 NOT A, 1100 B, 1101 B shifted right by one with zero fill, 1110 B shifted left by one with zero fill, and 1111 B. For these codes C and V are 0.
- R9: N equals the result MSB, and Z is 1 exactly when every result bit is 0.
- R10: A synchronous active-high reset clears all eight registers to zero.
- R11: Reads are combinational. A register that is both read and written in the same cycle shows its old value in that cycle and the new value from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_word | input | 16 | Packed control word for this cycle |
| const_in | input | W | Constant operand for the B side |
| ext_in | input | W | External writeback data |
| addr_out | output | W | First operand bus (A) |
| data_out | output | W | Second operand bus (B) |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry out |
| flag_n | output | 1 | Result negative |
| flag_z | output | 1 | Result zero |

## Verification
The two functions most likely to collide are a read and a write of the same register in one cycle. One control word provokes this: it names a register as destination and as both sources, with write enable set and a new external value on `ext_in`. In the cycle the word is applied, both buses must still carry the old contents. After the edge they must carry the new value. A second collision pairs the write-enable gate with a live writeback: a word with write enable 0 runs while `ext_in` and the function result both hold values that differ from the register contents. Every register is then read back unchanged.

// File: rtl/cwdp_pkg.sv
package cwdp_pkg;
   localparam int SEL_W   = 3;
   localparam int NUM_REG = 2 ** SEL_W;
   localparam int FN_W    = 4;
   localparam int CW_W    = 3 * SEL_W + FN_W + 3;

   typedef struct packed {
      logic [SEL_W-1:0] dst;
      logic [SEL_W-1:0] asel;
      logic [SEL_W-1:0] bsel;
      logic             bconst;
      logic [FN_W-1:0]  fn;
      logic             wsrc_ext;
      logic             wen;
   } ctrl_t;
endpackage

// File: rtl/cwdp_regfile.sv
module cwdp_regfile #(
   parameter int W     = 8,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [SEL_W-1:0] waddr,
   input  logic [W-1:0]     wdata,
   input  logic [SEL_W-1:0] raddr_a,
   input  logic [SEL_W-1:0] raddr_b,
   output logic [W-1:0]     rdata_a,
   output logic [W-1:0]     rdata_b
);
   localparam int DEPTH = 2 ** SEL_W;

   logic [W-1:0] entry [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (rst)
            entry[i] <= '0;
         else if (we && (waddr == SEL_W'(i)))
            entry[i] <= wdata;
      end
   end

   assign rdata_a = entry[raddr_a];
   assign rdata_b = entry[raddr_b];
endmodule

// File: rtl/cwdp_arith.sv
module cwdp_arith #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [2:0]   sel,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);
   logic [W-1:0] y;

   always_comb begin
      unique case (sel[2:1])
         2'b00:   y = '0;
         2'b01:   y = b;
         2'b10:   y = ~b;
         default: y = '1;
      endcase
   end

   assign {cout, sum} = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, sel[0]};
   assign ovf = (a[W-1] == y[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/cwdp_logic.sv
module cwdp_logic #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [2:0]   sel,
   output logic [W-1:0] res
);
   always_comb begin
      unique case (sel)
         3'b000:  res = a & b;
         3'b001:  res = a | b;
         3'b010:  res = a ^ b;
         3'b011:  res = ~a;
         3'b101:  res = {1'b0, b[W-1:1]};
         3'b110:  res = {b[W-2:0], 1'b0};
         default: res = b;
      endcase
   end
endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
   import cwdp_pkg::*;
#(
   parameter int W = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [CW_W-1:0] ctrl_word,
   input  logic [W-1:0]    const_in,
   input  logic [W-1:0]    ext_in,
   output logic [W-1:0]    addr_out,
   output logic [W-1:0]    data_out,
   output logic            flag_v,
   output logic            flag_c,
   output logic            flag_n,
   output logic            flag_z
);
   if (W < 2) begin : g_bad_width
      $error("cw_datapath: W must be at least 2");
   end
   if (CW_W != 16) begin : g_bad_word
      $error("cw_datapath: control word must be 16 bits");
   end

   ctrl_t        cw;
   logic [W-1:0] rd_a, rd_b, bus_b;
   logic [W-1:0] arith_res, logic_res, fu_res, wb_data;
   logic         arith_c, arith_v;

   assign cw = ctrl_t'(ctrl_word);

   cwdp_regfile #(.W(W), .SEL_W(SEL_W)) u_rf (
      .clk     (clk),
      .rst     (rst),
      .we      (cw.wen),
      .waddr   (cw.dst),
      .wdata   (wb_data),
      .raddr_a (cw.asel),
      .raddr_b (cw.bsel),
      .rdata_a (rd_a),
      .rdata_b (rd_b)
   );

   assign bus_b = cw.bconst ? const_in : rd_b;

   cwdp_arith #(.W(W)) u_arith (
      .a    (rd_a),
      .b    (bus_b),
      .sel  (cw.fn[2:0]),
      .sum  (arith_res),
      .cout (arith_c),
      .ovf  (arith_v)
   );

   cwdp_logic #(.W(W)) u_logic (
      .a   (rd_a),
      .b   (bus_b),
      .sel (cw.fn[2:0]),
      .res (logic_res)
   );

   assign fu_res  = cw.fn[FN_W-1] ? logic_res : arith_res;
   assign wb_data = cw.wsrc_ext ? ext_in : fu_res;

   assign addr_out = rd_a;
   assign data_out = bus_b;
   assign flag_c   = cw.fn[FN_W-1] ? 1'b0 : arith_c;
   assign flag_v   = cw.fn[FN_W-1] ? 1'b0 : arith_v;
   assign flag_n   = fu_res[W-1];
   assign flag_z   = (fu_res == '0);
endmodule

// File: rtl/cwdp_chk.sv
module cwdp_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst,
   input logic [15:0]  ctrl_word,
   input logic [W-1:0] ext_in,
   input logic [W-1:0] fu_res,
   input logic [W-1:0] addr_out,
   input logic [W-1:0] data_out,
   input logic         flag_v,
   input logic         flag_c,
   input logic         flag_n,
   input logic         flag_z
);
   // R1
   write_visible_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(ctrl_word[0]) && (ctrl_word[12:10] == $past(ctrl_word[15:13])))
      |-> (addr_out == $past(ctrl_word[1] ? ext_in : fu_res)));

   // R2
   no_write_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(ctrl_word[0]) && (ctrl_word[12:10] == $past(ctrl_word[12:10])))
      |-> $stable(addr_out));

   // R10
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (addr_out == '0) && (ctrl_word[6] || data_out == '0));

   // R8
   logic_flags_chk: assert property (@(posedge clk) disable iff (rst)
      ctrl_word[5] |-> (!flag_c && !flag_v));

   // R9
   zero_not_neg_chk: assert property (@(posedge clk) disable iff (rst)
      flag_z |-> !flag_n);
endmodule

bind cw_datapath cwdp_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .ctrl_word (ctrl_word),
   .ext_in    (ext_in),
   .fu_res    (fu_res),
   .addr_out  (addr_out),
   .data_out  (data_out),
   .flag_v    (flag_v),
   .flag_c    (flag_c),
   .flag_n    (flag_n),
   .flag_z    (flag_z)
);

// File: tb/cw_datapath_tb.sv
`timescale 1ns/1ps
module cw_datapath_tb;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst;
   logic [15:0]  ctrl_word;
   logic [W-1:0] const_in, ext_in;
   logic [W-1:0] addr_out, data_out;
   logic         flag_v, flag_c, flag_n, flag_z;

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   cw_datapath #(.W(W)) u_dut (
      .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .const_in(const_in),
      .ext_in(ext_in), .addr_out(addr_out), .data_out(data_out),
      .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
   );

   // {fn[4], a[8], b[8], result[8], vcnz[4]}
   localparam logic [31:0] VEC [18] = '{
      {4'b0010, 8'h7F, 8'h01, 8'h80, 4'b1010},
      {4'b0010, 8'hFF, 8'h01, 8'h00, 4'b0101},
      {4'b0101, 8'h05, 8'h05, 8'h00, 4'b0101},
      {4'b0101, 8'h03, 8'h05, 8'hFE, 4'b0010},
      {4'b0101, 8'h80, 8'h01, 8'h7F, 4'b1100},
      {4'b0001, 8'hFF, 8'h00, 8'h00, 4'b0101},
      {4'b0110, 8'h00, 8'h00, 8'hFF, 4'b0010},
      {4'b0011, 8'h10, 8'h20, 8'h31, 4'b0000},
      {4'b0000, 8'h5A, 8'h00, 8'h5A, 4'b0000},
      {4'b0111, 8'h80, 8'h00, 8'h80, 4'b0110},
      {4'b1000, 8'hF0, 8'h3C, 8'h30, 4'b0000},
      {4'b1001, 8'hF0, 8'h3C, 8'hFC, 4'b0010},
      {4'b1010, 8'hF0, 8'h3C, 8'hCC, 4'b0010},
      {4'b1011, 8'hF0, 8'h3C, 8'h0F, 4'b0000},
      {4'b1100, 8'hF0, 8'h3C, 8'h3C, 4'b0000},
      {4'b1101, 8'hF0, 8'h3C, 8'h1E, 4'b0000},
      {4'b1110, 8'h00, 8'h81, 8'h02, 4'b0000},
      {4'b1010, 8'h55, 8'h55, 8'h00, 4'b0001}
   };

   function automatic logic [15:0] mk(input logic [2:0] d, input logic [2:0] a,
                                      input logic [2:0] b, input logic bc,
                                      input logic [3:0] fn, input logic ws,
                                      input logic we);
      return {d, a, b, bc, fn, ws, we};
   endfunction

   task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, got, exp);
      end
   endtask

   task automatic drive(input logic [15:0] w, input logic [W-1:0] k, input logic [W-1:0] e);
      @(negedge clk);
      ctrl_word = w; const_in = k; ext_in = e;
      #1;
   endtask

   task automatic load(input logic [2:0] r, input logic [W-1:0] v);
      drive(mk(r, 3'd0, 3'd0, 1'b0, 4'd0, 1'b1, 1'b1), '0, v);
   endtask

   task automatic read_reg(input logic [2:0] r, input string req, input logic [W-1:0] exp);
      drive(mk(3'd0, r, r, 1'b0, 4'd0, 1'b0, 1'b0), '0, 8'hEE);
      chk(req, addr_out, exp);
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst = 1'b1; ctrl_word = '0; const_in = '0; ext_in = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;

      // R10: every register reads zero after reset, on both buses
      for (int r = 0; r < 8; r++) begin
         drive(mk(3'd0, 3'(r), 3'(r), 1'b0, 4'd0, 1'b0, 1'b0), 8'hAA, 8'hBB);
         chk("R10 A bus", addr_out, '0);
         chk("R10 B bus", data_out, '0);
      end

      // R5 R6 R7 R8 R9: vector table
      for (int i = 0; i < 18; i++) begin
         logic [3:0] fn;
         logic [7:0] va, vb, res;
         logic [3:0] fl;
         {fn, va, vb, res, fl} = VEC[i];
         load(3'd1, va);
         load(3'd2, vb);
         drive(mk(3'd3, 3'd1, 3'd2, 1'b0, fn, 1'b0, 1'b1), '0, 8'hEE);
         chk(fn[3] ? "R8 C" : "R6 C", W'(flag_c), W'(fl[2]));
         chk(fn[3] ? "R8 V" : "R7 V", W'(flag_v), W'(fl[3]));
         chk("R9 N", W'(flag_n), W'(fl[1]));
         chk("R9 Z", W'(flag_z), W'(fl[0]));
         chk("R4 B register", data_out, vb);
         read_reg(3'd3, fn[3] ? "R8 result R5" : "R6 result R5", res);
      end

      // R4: constant on the B side
      drive(mk(3'd0, 3'd1, 3'd2, 1'b1, 4'b1100, 1'b0, 1'b0), 8'hA5, 8'h00);
      chk("R4 constant", data_out, 8'hA5);
      chk("R8 pass const", W'(flag_n), W'(1'b1));

      // R3: A select walks registers
      load(3'd6, 8'h66);
      load(3'd7, 8'h77);
      read_reg(3'd6, "R3 reg6", 8'h66);
      read_reg(3'd7, "R3 reg7", 8'h77);

      // R1: doc-style word loads register 4 from external data
      drive(16'b1000000110011011, 8'h00, 8'h4C);
      read_reg(3'd4, "R1 load reg4", 8'h4C);

      // R2: no-write word, register 2 and register 4 untouched
      load(3'd2, 8'h22);
      drive(16'b0100000110011000, 8'h11, 8'h11);
      drive(mk(3'd2, 3'd4, 3'd2, 1'b0, 4'b0001, 1'b1, 1'b0), 8'h99, 8'h99);
      read_reg(3'd2, "R2 reg2 kept", 8'h22);
      read_reg(3'd4, "R2 reg4 kept", 8'h4C);

      // R11: read and write of register 5 in one cycle
      load(3'd5, 8'h50);
      drive(mk(3'd5, 3'd5, 3'd5, 1'b0, 4'd0, 1'b1, 1'b1), 8'h00, 8'h99);
      chk("R11 old A", addr_out, 8'h50);
      chk("R11 old B", data_out, 8'h50);
      drive(mk(3'd0, 3'd5, 3'd5, 1'b0, 4'd0, 1'b0, 1'b0), 8'h00, 8'h00);
      chk("R11 new A", addr_out, 8'h99);
      chk("R11 new B", data_out, 8'h99);

      // R10: reset mid-run clears loaded registers
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      read_reg(3'd4, "R10 reg4 cleared", 8'h00);
      read_reg(3'd7, "R10 reg7 cleared", 8'h00);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule